// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Mode

This block keeps time of day and calendar date: seconds, minutes, hours, a weekday counter, day of month, month and a two-digit year. A single-cycle `tick` pulse, expected once per second, advances the seconds. Carries ripple up through every field to the year. Each field is presented as a packed-BCD register byte. The hours byte is shown in either 24-hour form or 12-hour form with an AM/PM flag, depending on a mode bit that software sets.

Software sets the time with a field index and a data byte on a single-cycle write strobe. The data byte is decoded from BCD under a fixed mask for each field. Internally the hours always count 0 to 23. Conversion to and from 12-hour form happens only at the register boundary. The weekday is a free-running 1..7 counter that steps at midnight and is never derived from the date. Oscillator control is not modelled, and bit 7 of the seconds byte is discarded.

Top module: `bcdclk_top`

## Requirements
- R1: After reset the outputs read 00 seconds, 00 minutes, hour 00 in 24-hour mode, weekday 1, date 01, month 01 and year 00.
- R2: Each accepted tick adds one to the seconds. Seconds roll from 59 to 00 and carry into the minutes, and minutes roll from 59 to 00 and carry into the hours.
- R3: Hours roll from 23 to 0 and carry into the day. On that carry the weekday steps by one, and from 7 it wraps to 1, whatever the date is.
- R4: The date rolls over to 01 after the last day of its month, with a carry into the month. April, June, September and November have 30 days, and the other months except February have 31. February has 29 days when the year is a multiple of 4 and 28 days otherwise.
- R5: The month rolls from 12 to 01 with a carry into the year, and the year rolls from 99 to 00.
- R6: Write field indices are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month and 6 year. Seconds and minutes take data bits 6:0 as BCD, so bit 7 is dropped. The weekday takes bits 2:0 in binary. The date takes bits 5:0 as BCD, the month takes bits 4:0 as BCD, and the year takes all 8 bits as BCD.
- R7: An hours write with bit 6 clear selects 24-hour mode and takes bits 5:0 as the BCD hour. In 24-hour mode the hours output is plain BCD 00 to 23.
- R8: An hours write with bit 6 set selects 12-hour mode. The hour is the BCD value in bits 4:0, plus 12 when bit 5 (PM) is set, and a result of 12 becomes hour 0 while a result of 24 becomes hour 12.
- R9: In 12-hour mode the hours output has bit 6 set and bit 5 set for hours 12 to 23. Bits 4:0 hold the BCD hour 1 to 12: internal hour 0 reads 0x52, hour 12 reads 0x72, and hours 13 to 23 read 1 to 11 with PM.
- R10: The 12/24-hour mode persists across any number of ticks and rollovers and changes only on an hours write.
- R11: A write shows on the outputs after the next rising clock edge. A tick in the same cycle as a write to indices 0 to 6 is dropped.
- R12: A write to index 7 changes no field, and a tick in that cycle is still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| wrEn | input | 1 | Field write strobe |
| wrIdx | input | 3 | Field index for a write |
| wrData | input | 8 | Register-format data for a write |
| secOut | output | 8 | Seconds, BCD |
| minOut | output | 8 | Minutes, BCD |
| hourOut | output | 8 | Hours, BCD, with mode and PM flags in 12-hour mode |
| wdayOut | output | 8 | Weekday 1 to 7 |
| dateOut | output | 8 | Day of month, BCD |
| monOut | output | 8 | Month, BCD |
| yearOut | output | 8 | Year, BCD |

## Verification
There is one register stage between the inputs and the outputs. A write or a tick presented in one cycle therefore appears on all seven field outputs after exactly one rising edge, including a full ripple from seconds to year. Inputs are driven after a falling edge, and all seven outputs are compared at the following falling edge against a bench model that has been stepped once. In this way every rollover, every write and every tick dropped because of a write is checked in the cycle it becomes due. Random ticks and random writes of legal values run after directed cases that land on each month length, the leap rule, the year wrap and the 12 AM and 12 PM corners.

// File: rtl/bcdclk_pkg.sv
package bcdclk_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int IDX_W      = 3;
  localparam int BYTE_W     = 8;
  localparam int LEAP_MOD_W = 2;  // leap year when the low bits of the year are zero

  typedef enum logic [IDX_W-1:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_WDAY = 3'd3,
    F_DATE = 3'd4, F_MON = 3'd5, F_YEAR = 3'd6
  } fieldE;

  typedef struct packed {
    logic                  tickEn;
    logic [NUM_FIELDS-1:0] wrSel;
    logic [BYTE_W-1:0]     data;
  } strobeT;

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    logic [3:0] tens;
    tens = 4'd0;
    for (int k = 1; k < 10; k++)
      if (v >= 7'(k * 10)) tens = 4'(k);
    return {tens, 4'(v - 7'(tens) * 7'd10)};
  endfunction

  function automatic logic [4:0] monthLen(input logic [3:0] mon, input logic [6:0] year);
    case (mon)
      4'd2:                        return (year[LEAP_MOD_W-1:0] == '0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:     return 5'd30;
      default:                     return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/bcdclk_ctrl.sv
module bcdclk_ctrl
  import bcdclk_pkg::*;
(
  input  logic              tick,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [BYTE_W-1:0] wrData,
  output strobeT            strOut
);
  logic [NUM_FIELDS-1:0] sel;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_sel
    assign sel[g] = wrEn && (wrIdx == IDX_W'(g));
  end

  // a write to a real field wins over the tick (R11); index 7 decodes to nothing (R12)
  assign strOut.wrSel  = sel;
  assign strOut.tickEn = tick && !(|sel);
  assign strOut.data   = wrData;
endmodule

// File: rtl/bcdclk_dp.sv
module bcdclk_dp
  import bcdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            str,
  output logic [BYTE_W-1:0] secBcd,
  output logic [BYTE_W-1:0] minBcd,
  output logic [BYTE_W-1:0] hourBcd,
  output logic [BYTE_W-1:0] wdayBcd,
  output logic [BYTE_W-1:0] dateBcd,
  output logic [BYTE_W-1:0] monBcd,
  output logic [BYTE_W-1:0] yearBcd
);
  logic [5:0] secQ, minQ;
  logic [4:0] hourQ, dateQ;
  logic       mode12Q;
  logic [2:0] wdayQ;
  logic [3:0] monQ;
  logic [6:0] yearQ;

  logic secWrap, minWrap, hourWrap, dateWrap, monWrap;
  logic [5:0] h12Raw;
  logic [4:0] hourWr, hShow;

  assign secWrap  = (secQ == 6'd59);
  assign minWrap  = secWrap && (minQ == 6'd59);
  assign hourWrap = minWrap && (hourQ == 5'd23);
  assign dateWrap = hourWrap && (dateQ >= monthLen(monQ, yearQ));
  assign monWrap  = dateWrap && (monQ == 4'd12);

  always_comb begin
    h12Raw = 6'(bcd2bin({3'b000, str.data[4:0]})) + (str.data[5] ? 6'd12 : 6'd0);
    if (str.data[6]) begin
      if (h12Raw == 6'd12)      hourWr = 5'd0;
      else if (h12Raw == 6'd24) hourWr = 5'd12;
      else                      hourWr = 5'(h12Raw);
    end else begin
      hourWr = 5'(bcd2bin({2'b00, str.data[5:0]}));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= '0; minQ <= '0; hourQ <= '0; mode12Q <= 1'b0;
      wdayQ <= 3'd1; dateQ <= 5'd1; monQ <= 4'd1; yearQ <= '0;
    end else if (|str.wrSel) begin
      if (str.wrSel[F_SEC])  secQ  <= 6'(bcd2bin({1'b0, str.data[6:0]}));
      if (str.wrSel[F_MIN])  minQ  <= 6'(bcd2bin({1'b0, str.data[6:0]}));
      if (str.wrSel[F_HOUR]) begin
        hourQ   <= hourWr;
        mode12Q <= str.data[6];
      end
      if (str.wrSel[F_WDAY]) wdayQ <= str.data[2:0];
      if (str.wrSel[F_DATE]) dateQ <= 5'(bcd2bin({2'b00, str.data[5:0]}));
      if (str.wrSel[F_MON])  monQ  <= 4'(bcd2bin({3'b000, str.data[4:0]}));
      if (str.wrSel[F_YEAR]) yearQ <= bcd2bin(str.data);
    end else if (str.tickEn) begin
      secQ <= secWrap ? 6'd0 : secQ + 6'd1;
      if (secWrap) minQ <= minWrap ? 6'd0 : minQ + 6'd1;
      if (minWrap) hourQ <= hourWrap ? 5'd0 : hourQ + 5'd1;
      if (hourWrap) begin
        wdayQ <= (wdayQ == 3'd7) ? 3'd1 : wdayQ + 3'd1;
        dateQ <= dateWrap ? 5'd1 : dateQ + 5'd1;
      end
      if (dateWrap) monQ <= monWrap ? 4'd1 : monQ + 4'd1;
      if (monWrap) yearQ <= (yearQ == 7'd99) ? 7'd0 : yearQ + 7'd1;
    end
  end

  // register-format read encoding
  always_comb begin
    if (hourQ == 5'd0)       hShow = 5'd12;
    else if (hourQ > 5'd12)  hShow = hourQ - 5'd12;
    else                     hShow = hourQ;
  end

  assign hourBcd = mode12Q
                 ? (8'h40 | ((hourQ >= 5'd12) ? 8'h20 : 8'h00) | bin2bcd(7'(hShow)))
                 : bin2bcd(7'(hourQ));
  assign secBcd  = bin2bcd(7'(secQ));
  assign minBcd  = bin2bcd(7'(minQ));
  assign wdayBcd = {5'b00000, wdayQ};
  assign dateBcd = bin2bcd(7'(dateQ));
  assign monBcd  = bin2bcd(7'(monQ));
  assign yearBcd = bin2bcd(yearQ);

  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (str.tickEn && secQ != 6'd59) |=> (secQ == 6'($past(secQ) + 6'd1)));
  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (str.tickEn && secQ == 6'd59) |=> (secQ == 6'd0));
  p_wday_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (str.tickEn && secQ == 6'd59 && minQ == 6'd59 && hourQ == 5'd23 && wdayQ == 3'd7)
      |=> (wdayQ == 3'd1));
  p_mode_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    !str.wrSel[F_HOUR] |=> $stable(mode12Q));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!str.tickEn && str.wrSel == '0)
      |=> ($stable(secQ) && $stable(hourQ) && $stable(dateQ) && $stable(yearQ)));
endmodule

// File: rtl/bcdclk_top.sv
module bcdclk_top
  import bcdclk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        wrEn,
  input  logic [2:0]  wrIdx,
  input  logic [7:0]  wrData,
  output logic [7:0]  secOut,
  output logic [7:0]  minOut,
  output logic [7:0]  hourOut,
  output logic [7:0]  wdayOut,
  output logic [7:0]  dateOut,
  output logic [7:0]  monOut,
  output logic [7:0]  yearOut
);
  strobeT str;

  bcdclk_ctrl ctrl_i (
    .tick(tick), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .strOut(str)
  );

  bcdclk_dp dp_i (
    .clk(clk), .rstN(rstN), .str(str),
    .secBcd(secOut), .minBcd(minOut), .hourBcd(hourOut), .wdayBcd(wdayOut),
    .dateBcd(dateOut), .monBcd(monOut), .yearBcd(yearOut)
  );

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && tick && wrIdx == 3'd3) |=> $stable(secOut));
endmodule

// File: tb/bcdclk_top_tb_top.sv
module bcdclk_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, wrEn = 1'b0;
  logic [2:0] wrIdx = '0;
  logic [7:0] wrData = '0;
  logic [7:0] secOut, minOut, hourOut, wdayOut, dateOut, monOut, yearOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcdclk_top dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .wdayOut(wdayOut),
    .dateOut(dateOut), .monOut(monOut), .yearOut(yearOut)
  );

  int nChk = 0, nFail = 0;
  bit done = 0;
  int mSec = 0, mMin = 0, mHour = 0, mWday = 1, mDate = 1, mMon = 1, mYear = 0;
  bit mMode = 0;

  function automatic logic [7:0] toBcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int fromBcd(int b);
    return ((b >> 4) & 15) * 10 + (b & 15);
  endfunction
  function automatic int mLen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] encHour(int h, bit twelve);
    int t;
    if (!twelve) return toBcd(h);
    t = (h % 12 == 0) ? 12 : h % 12;
    return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | toBcd(t);
  endfunction

  task automatic modelTick();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHour++;
        if (mHour == 24) begin
          mHour = 0;
          mWday = (mWday == 7) ? 1 : mWday + 1;
          if (mDate == mLen(mMon, mYear)) begin
            mDate = 1; mMon++;
            if (mMon == 13) begin mMon = 1; mYear = (mYear + 1) % 100; end
          end else mDate++;
        end
      end
    end
  endtask

  task automatic modelWrite(int idx, logic [7:0] d);
    int h;
    case (idx)
      0: mSec = fromBcd(d & 8'h7f);
      1: mMin = fromBcd(d & 8'h7f);
      2: if (d[6]) begin
           h = fromBcd(d & 8'h1f) + (d[5] ? 12 : 0);
           if (h == 12) h = 0; else if (h == 24) h = 12;
           mHour = h; mMode = 1;
         end else begin
           mHour = fromBcd(d & 8'h3f); mMode = 0;
         end
      3: mWday = d & 7;
      4: mDate = fromBcd(d & 8'h3f);
      5: mMon = fromBcd(d & 8'h1f);
      6: mYear = fromBcd(d);
      default: ;
    endcase
  endtask

  task automatic chk(string req, string name, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, name, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    chk(req, "sec", secOut, toBcd(mSec));
    chk(req, "min", minOut, toBcd(mMin));
    chk(req, "hour", hourOut, encHour(mHour, mMode));
    chk(req, "wday", wdayOut, 8'(mWday));
    chk(req, "date", dateOut, toBcd(mDate));
    chk(req, "mon", monOut, toBcd(mMon));
    chk(req, "year", yearOut, toBcd(mYear));
  endtask

  // inputs change after a falling edge; results sampled at the next falling edge
  task automatic cyc(bit t, bit w, int idx, logic [7:0] d, string req);
    tick = t; wrEn = w; wrIdx = 3'(idx); wrData = d;
    @(negedge clk);
    if (w && idx < 7) modelWrite(idx, d);
    else if (t) modelTick();
    tick = 0; wrEn = 0;
    checkAll(req);
  endtask

  task automatic setAll(int s, int mi, logic [7:0] hb, int wd, int dt, int mo, int yr, string req);
    cyc(0, 1, 6, toBcd(yr), req);
    cyc(0, 1, 5, toBcd(mo), req);
    cyc(0, 1, 4, toBcd(dt), req);
    cyc(0, 1, 3, 8'(wd), req);
    cyc(0, 1, 2, hb, req);
    cyc(0, 1, 1, toBcd(mi), req);
    cyc(0, 1, 0, toBcd(s), req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int idx, v;
    bit twelve;
    repeat (3) @(negedge clk);
    rstN = 1;
    checkAll("R1");
    cyc(0, 0, 0, 8'h00, "R1");

    // R6: seconds bit 7 discarded, then R2 carry into minutes
    cyc(0, 1, 0, 8'hD8, "R6");
    cyc(1, 0, 0, 8'h00, "R2");
    cyc(1, 0, 0, 8'h00, "R2");

    // R5/R3: full ripple at year end, weekday 7 -> 1
    setAll(58, 59, 8'h23, 7, 31, 12, 99, "R6");
    cyc(1, 0, 0, 8'h00, "R3");
    cyc(1, 0, 0, 8'h00, "R5");

    // R4: leap February, non-leap February, 30-day month
    setAll(59, 59, 8'h23, 2, 28, 2, 4, "R4");
    cyc(1, 0, 0, 8'h00, "R4");
    setAll(59, 59, 8'h23, 3, 29, 2, 4, "R4");
    cyc(1, 0, 0, 8'h00, "R4");
    setAll(59, 59, 8'h23, 4, 28, 2, 5, "R4");
    cyc(1, 0, 0, 8'h00, "R4");
    setAll(59, 59, 8'h23, 5, 30, 4, 10, "R4");
    cyc(1, 0, 0, 8'h00, "R4");
    setAll(59, 59, 8'h23, 6, 30, 1, 10, "R4");
    cyc(1, 0, 0, 8'h00, "R4");

    // R8/R9: 12 AM, 12 PM, 11 PM, then 24-hour write (R7)
    cyc(0, 1, 2, 8'h52, "R8");
    cyc(0, 1, 2, 8'h72, "R8");
    cyc(0, 1, 2, 8'h71, "R9");
    cyc(0, 1, 2, 8'h41, "R9");
    cyc(0, 1, 2, 8'h23, "R7");
    cyc(0, 1, 2, 8'hC9, "R8");

    // R10: mode survives rollover 11 AM -> 12 PM and midnight
    setAll(59, 59, 8'h51, 1, 10, 3, 20, "R10");
    cyc(1, 0, 0, 8'h00, "R10");
    setAll(59, 59, 8'h71, 1, 10, 3, 20, "R10");
    cyc(1, 0, 0, 8'h00, "R10");

    // R11: write wins over tick; R12: index 7 ignored, tick accepted
    cyc(1, 1, 1, toBcd(7), "R11");
    cyc(1, 1, 3, 8'h05, "R11");
    cyc(1, 1, 7, 8'h99, "R12");
    cyc(0, 1, 7, 8'h12, "R12");
    cyc(0, 1, 4, toBcd(1), "R6");

    // random phase
    v = $urandom(32'd4242);
    for (int n = 0; n < 4000; n++) begin
      bit t, w;
      t = ($urandom % 2) == 0;
      w = ($urandom % 4) == 0;
      idx = $urandom % 8;
      case (idx)
        0, 1: d = toBcd($urandom % 60) | ((($urandom % 2) == 1) ? 8'h80 : 8'h00);
        2: begin twelve = ($urandom % 2) == 1; d = encHour($urandom % 24, twelve); end
        3: d = 8'(1 + $urandom % 7);
        4: d = toBcd(1 + $urandom % 28);
        5: begin
             if (mDate > 28) begin idx = 4; d = toBcd(1 + $urandom % 28); end
             else d = toBcd(1 + $urandom % 12);
           end
        6: d = toBcd($urandom % 100);
        default: d = 8'($urandom);
      endcase
      cyc(t, w, idx, d, (w && idx < 7) ? "R11" : "R2");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule